// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the machine-mode control and status registers of a 64-bit RISC-V integer pipeline. It executes the six CSR read-modify-write instructions (write, set and clear, each with a register operand or a 5-bit zero-extended immediate). It also handles the synchronous exception raised by an environment call, and the return from that trap. The registers it keeps are the status word, the trap vector, the exception PC, the trap cause and a free-running cycle counter. No interrupt is ever taken.

The pipeline presents a CSR address, the instruction's funct3 as an operation code, the rs1 index field (which doubles as the immediate), the rs1 register value and a write-back enable. `rdData` always shows the value the addressed CSR held before this cycle's update, so the pipeline can write it to rd. A trap request carries the faulting PC, and a trap-return request marks an mret. Either request raises `redirectValid` in the same cycle, with the fetch target on `redirectPc`. Register updates take effect at the next rising clock edge.

Top module: `mcsr_trap_unit`

## Requirements
- R1: `csrOp` encodes 3'b001 write, 3'b010 set, 3'b011 clear, and 3'b101/3'b110/3'b111 the same three with the operand `{59'b0, rs1Idx}` instead of `rs1Val`. Codes 3'b000 and 3'b100 do nothing, and no operation writes unless `wbEn` is 1.
- R2: `rdData` equals, in the same cycle, the pre-update value of the addressed CSR: 12'h300 status, 12'h305 trap vector, 12'h341 exception PC, 12'h342 cause, 12'hB00 cycle counter. Any other address reads 0 and a write to it changes nothing.
- R3: A set or clear with `rs1Idx` equal to 0 leaves the CSR unchanged, whatever `rs1Val` holds. A write with `rs1Idx` equal to 0 still writes (the immediate form writes 0).
- R4: The cycle counter increases by one on every clock edge out of reset.
- R5: A CSR write to the cycle counter loads the written value at that edge in place of the increment.
- R6: A trap request sets the cause to 11 and the exception PC to `trapPc`. In the same cycle it asserts `redirectValid` with `redirectPc` equal to the trap vector with bits 1:0 cleared.
- R7: On trap entry, status bit 7 takes the old value of status bit 3, and status bit 3 is cleared.
- R8: A trap-return request asserts `redirectValid` with `redirectPc` equal to the exception PC. It then copies status bit 7 into bit 3 and sets bit 7.
- R9: A trap request takes precedence over a trap return, and either one suppresses a CSR write in the same cycle. With neither request, `redirectValid` is 0.
- R10: After reset every CSR, including the cycle counter, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrAddr | input | 12 | CSR address |
| csrOp | input | 3 | CSR operation code (funct3) |
| rs1Idx | input | 5 | rs1 index, also the immediate operand |
| rs1Val | input | 64 | rs1 register value |
| wbEn | input | 1 | Permits the CSR write this cycle |
| trapReq | input | 1 | Environment-call trap request |
| trapPc | input | 64 | PC of the trapping instruction |
| mretReq | input | 1 | Trap-return request |
| rdData | output | 64 | Pre-update value of the addressed CSR |
| redirectPc | output | 64 | Fetch redirect target |
| redirectValid | output | 1 | Redirect strobe |

## Verification
Every cycle, the assertions check three things: that a redirect appears exactly when a trap or trap return is requested, and that a trap target is word aligned. They check that a trap followed at once by a trap return goes back to the faulting PC. They also check the counter's step, the loading of a counter write, the status word being left alone by a zero-operand set or clear, and the interrupt-enable bit being cleared after a trap, whenever the next cycle reads the register involved. The bench's scenarios are needed to show the read-before-update values for all six operation forms. They are also needed for the exact cause and exception-PC contents, the restore of the enable bits on return, and the precedence between simultaneous requests. Unmapped addresses and the suppressed write when `wbEn` is low are shown only by the bench as well.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam logic [11:0] ADDR_STATUS = 12'h300;
  localparam logic [11:0] ADDR_TVEC   = 12'h305;
  localparam logic [11:0] ADDR_EPC    = 12'h341;
  localparam logic [11:0] ADDR_CAUSE  = 12'h342;
  localparam logic [11:0] ADDR_CYCLE  = 12'hB00;

  typedef enum logic [1:0] {
    WK_NONE = 2'b00,
    WK_RW   = 2'b01,
    WK_SET  = 2'b10,
    WK_CLR  = 2'b11
  } wrKind_e;

  typedef struct packed {
    logic    selStatus;
    logic    selTvec;
    logic    selEpc;
    logic    selCause;
    logic    selCycle;
    logic    csrWrite;
    wrKind_e kind;
    logic    useImm;
    logic    trapEnter;
    logic    trapReturn;
  } csrStrobe_t;
endpackage

// File: rtl/mcsr_ctrl.sv
module mcsr_ctrl
  import mcsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 5
) (
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [2:0]        csrOp,
  input  logic [IDX_W-1:0]  rs1Idx,
  input  logic              wbEn,
  input  logic              trapReq,
  input  logic              mretReq,
  output csrStrobe_t        strobe
);
  wrKind_e kind;
  logic    zeroSrc;
  logic    opLive;

  assign kind    = wrKind_e'(csrOp[1:0]);
  assign zeroSrc = (rs1Idx == '0);
  assign opLive  = wbEn && (kind != WK_NONE) && !trapReq && !mretReq;

  always_comb begin
    strobe            = '0;
    strobe.selStatus  = (csrAddr == ADDR_W'(ADDR_STATUS));
    strobe.selTvec    = (csrAddr == ADDR_W'(ADDR_TVEC));
    strobe.selEpc     = (csrAddr == ADDR_W'(ADDR_EPC));
    strobe.selCause   = (csrAddr == ADDR_W'(ADDR_CAUSE));
    strobe.selCycle   = (csrAddr == ADDR_W'(ADDR_CYCLE));
    strobe.kind       = kind;
    strobe.useImm     = csrOp[2];
    strobe.csrWrite   = opLive && ((kind == WK_RW) || !zeroSrc);
    strobe.trapEnter  = trapReq;
    strobe.trapReturn = mretReq && !trapReq;
  end
endmodule

// File: rtl/mcsr_dpath.sv
module mcsr_dpath
  import mcsr_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int IDX_W      = 5,
  parameter int CAUSE_CODE = 11,
  parameter int MIE_BIT    = 3,
  parameter int MPIE_BIT   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  csrStrobe_t       strobe,
  input  logic [IDX_W-1:0] rs1Idx,
  input  logic [XLEN-1:0]  rs1Val,
  input  logic [XLEN-1:0]  trapPc,
  output logic [XLEN-1:0]  rdData,
  output logic [XLEN-1:0]  redirectPc,
  output logic             redirectValid
);
  localparam int PAD_W = XLEN - IDX_W;

  logic [XLEN-1:0] statusQ, tvecQ, epcQ, causeQ, cycleQ;
  logic [XLEN-1:0] operand, newVal, oldVal;

  assign oldVal = ({XLEN{strobe.selStatus}} & statusQ)
                | ({XLEN{strobe.selTvec}}   & tvecQ)
                | ({XLEN{strobe.selEpc}}    & epcQ)
                | ({XLEN{strobe.selCause}}  & causeQ)
                | ({XLEN{strobe.selCycle}}  & cycleQ);
  assign rdData  = oldVal;
  assign operand = strobe.useImm ? {{PAD_W{1'b0}}, rs1Idx} : rs1Val;

  always_comb begin
    unique case (strobe.kind)
      WK_SET:  newVal = oldVal | operand;
      WK_CLR:  newVal = oldVal & ~operand;
      default: newVal = operand;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else if (strobe.trapEnter) begin
      statusQ[MPIE_BIT] <= statusQ[MIE_BIT];
      statusQ[MIE_BIT]  <= 1'b0;
    end else if (strobe.trapReturn) begin
      statusQ[MIE_BIT]  <= statusQ[MPIE_BIT];
      statusQ[MPIE_BIT] <= 1'b1;
    end else if (strobe.csrWrite && strobe.selStatus) begin
      statusQ <= newVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= '0;
      epcQ   <= '0;
    end else if (strobe.trapEnter) begin
      causeQ <= XLEN'(CAUSE_CODE);
      epcQ   <= trapPc;
    end else if (strobe.csrWrite) begin
      if (strobe.selCause) causeQ <= newVal;
      if (strobe.selEpc)   epcQ   <= newVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tvecQ <= '0;
    end else if (strobe.csrWrite && strobe.selTvec) begin
      tvecQ <= newVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleQ <= '0;
    end else if (strobe.csrWrite && strobe.selCycle) begin
      cycleQ <= newVal;
    end else begin
      cycleQ <= cycleQ + 1'b1;
    end
  end

  assign redirectValid = strobe.trapEnter || strobe.trapReturn;

  always_comb begin
    if (strobe.trapEnter)       redirectPc = {tvecQ[XLEN-1:2], 2'b00};
    else if (strobe.trapReturn) redirectPc = epcQ;
    else                        redirectPc = '0;
  end
endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
  import mcsr_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [2:0]        csrOp,
  input  logic [IDX_W-1:0]  rs1Idx,
  input  logic [XLEN-1:0]   rs1Val,
  input  logic              wbEn,
  input  logic              trapReq,
  input  logic [XLEN-1:0]   trapPc,
  input  logic              mretReq,
  output logic [XLEN-1:0]   rdData,
  output logic [XLEN-1:0]   redirectPc,
  output logic              redirectValid
);
  csrStrobe_t strobe;

  mcsr_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uCtrl (
    .csrAddr (csrAddr),
    .csrOp   (csrOp),
    .rs1Idx  (rs1Idx),
    .wbEn    (wbEn),
    .trapReq (trapReq),
    .mretReq (mretReq),
    .strobe  (strobe)
  );

  mcsr_dpath #(.XLEN(XLEN), .IDX_W(IDX_W)) uDpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .rs1Idx        (rs1Idx),
    .rs1Val        (rs1Val),
    .trapPc        (trapPc),
    .rdData        (rdData),
    .redirectPc    (redirectPc),
    .redirectValid (redirectValid)
  );
endmodule

// File: rtl/mcsr_trap_chk.sv
module mcsr_trap_chk
  import mcsr_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] csrAddr,
  input logic [2:0]        csrOp,
  input logic [IDX_W-1:0]  rs1Idx,
  input logic [XLEN-1:0]   rs1Val,
  input logic              wbEn,
  input logic              trapReq,
  input logic [XLEN-1:0]   trapPc,
  input logic              mretReq,
  input logic [XLEN-1:0]   rdData,
  input logic [XLEN-1:0]   redirectPc,
  input logic              redirectValid
);
  // R6
  trap_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (redirectValid && redirectPc[1:0] == 2'b00));

  // R9
  no_spurious_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trapReq && !mretReq) |-> !redirectValid);

  // R8
  return_to_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> (!(mretReq && !trapReq) || (redirectValid && redirectPc == $past(trapPc))));

  // R4
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == ADDR_W'(ADDR_CYCLE) && !wbEn)
      |=> (csrAddr != ADDR_W'(ADDR_CYCLE) || rdData == $past(rdData) + 1'b1));

  // R5
  cycle_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == ADDR_W'(ADDR_CYCLE) && wbEn && csrOp == 3'b001 && !trapReq && !mretReq)
      |=> (csrAddr != ADDR_W'(ADDR_CYCLE) || rdData == $past(rs1Val)));

  // R3
  zero_src_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == ADDR_W'(ADDR_STATUS) && wbEn && csrOp[1] && rs1Idx == '0 && !trapReq && !mretReq)
      |=> (csrAddr != ADDR_W'(ADDR_STATUS) || rdData == $past(rdData)));

  // R7
  trap_mie_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> (csrAddr != ADDR_W'(ADDR_STATUS) || rdData[3] == 1'b0));
endmodule

bind mcsr_trap_unit mcsr_trap_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) uChk (.*);

// File: tb/mcsr_trap_unit_test.sv
`timescale 1ns/1ps
module mcsr_trap_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [2:0]  csrOp = '0;
  logic [4:0]  rs1Idx = '0;
  logic [63:0] rs1Val = '0;
  logic        wbEn = 1'b0;
  logic        trapReq = 1'b0;
  logic [63:0] trapPc = '0;
  logic        mretReq = 1'b0;
  logic [63:0] rdData, redirectPc;
  logic        redirectValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mcsr_trap_unit uut (.*);

  string       tagQ[$];
  logic [63:0] rdQ[$];
  logic        vQ[$];
  logic [63:0] pcQ[$];
  event        sampleEv;

  logic [63:0] mSt = 0, mTv = 0, mEp = 0, mCa = 0, mCy = 0;

  function automatic logic [63:0] rdModel(input logic [11:0] a);
    case (a)
      12'h300: return mSt;
      12'h305: return mTv;
      12'h341: return mEp;
      12'h342: return mCa;
      12'hB00: return mCy;
      default: return 64'd0;
    endcase
  endfunction

  initial begin
    forever begin
      string t; logic [63:0] er, ep; logic ev;
      @(sampleEv);
      t = tagQ.pop_front(); er = rdQ.pop_front(); ev = vQ.pop_front(); ep = pcQ.pop_front();
      checks++;
      if (rdData !== er) begin
        errors++; $display("FAIL %s rdData actual %h expected %h", t, rdData, er);
      end
      checks++;
      if (redirectValid !== ev) begin
        errors++; $display("FAIL %s redirectValid actual %b expected %b", t, redirectValid, ev);
      end
      if (ev) begin
        checks++;
        if (redirectPc !== ep) begin
          errors++; $display("FAIL %s redirectPc actual %h expected %h", t, redirectPc, ep);
        end
      end
    end
  end

  task automatic step(input string tag, input logic [11:0] a, input logic [2:0] op,
                      input logic [4:0] idx, input logic [63:0] val, input logic wb,
                      input logic trp, input logic [63:0] tpc, input logic mr);
    logic [63:0] old, opd, nv;
    old = rdModel(a);
    tagQ.push_back(tag);
    rdQ.push_back(old);
    vQ.push_back(trp | mr);
    pcQ.push_back(trp ? {mTv[63:2], 2'b00} : (mr ? mEp : 64'd0));
    csrAddr = a; csrOp = op; rs1Idx = idx; rs1Val = val; wbEn = wb;
    trapReq = trp; trapPc = tpc; mretReq = mr;
    #1;
    -> sampleEv;
    if (trp) begin
      mCa = 64'd11; mEp = tpc; mSt[7] = mSt[3]; mSt[3] = 1'b0; mCy = mCy + 1;
    end else if (mr) begin
      mSt[3] = mSt[7]; mSt[7] = 1'b1; mCy = mCy + 1;
    end else if (wb && op[1:0] != 2'b00 && (op[1:0] == 2'b01 || idx != 0)) begin
      opd = op[2] ? {59'd0, idx} : val;
      case (op[1:0])
        2'b10:   nv = old | opd;
        2'b11:   nv = old & ~opd;
        default: nv = opd;
      endcase
      mCy = mCy + 1;
      case (a)
        12'h300: mSt = nv;
        12'h305: mTv = nv;
        12'h341: mEp = nv;
        12'h342: mCa = nv;
        12'hB00: mCy = nv;
        default: ;
      endcase
    end else begin
      mCy = mCy + 1;
    end
    @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    step(tag, a, 3'b000, 5'd0, 64'd0, 1'b0, 1'b0, 64'd0, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    rd("R10 cycle", 12'hB00);
    rd("R10 status", 12'h300);
    rd("R10 tvec", 12'h305);
    rd("R10 epc", 12'h341);
    rd("R10 cause", 12'h342);
    // R1 R2 register write form
    step("R1 tvec write", 12'h305, 3'b001, 5'd1, 64'h0000_0000_8000_0103, 1, 0, 0, 0);
    rd("R2 tvec read", 12'h305);
    step("R1 status set", 12'h300, 3'b010, 5'd2, 64'h88, 1, 0, 0, 0);
    step("R1 status clear imm", 12'h300, 3'b111, 5'd8, 64'hFFFF, 1, 0, 0, 0);
    step("R1 status set imm", 12'h300, 3'b110, 5'd8, 64'h0, 1, 0, 0, 0);
    step("R1 status clear reg", 12'h300, 3'b011, 5'd4, 64'h80, 1, 0, 0, 0);
    step("R1 status write imm", 12'h300, 3'b101, 5'd9, 64'h0, 1, 0, 0, 0);
    rd("R1 status read", 12'h300);
    // R3 zero operand
    step("R3 seti zero", 12'h300, 3'b110, 5'd0, 64'hFF, 1, 0, 0, 0);
    step("R3 set reg x0", 12'h300, 3'b010, 5'd0, 64'hFF, 1, 0, 0, 0);
    step("R3 clear reg x0", 12'h300, 3'b011, 5'd0, 64'hFF, 1, 0, 0, 0);
    rd("R3 status unchanged", 12'h300);
    step("R3 epc write", 12'h341, 3'b001, 5'd3, 64'h1234_5678, 1, 0, 0, 0);
    step("R3 epc write imm zero", 12'h341, 3'b101, 5'd0, 64'hABCD, 1, 0, 0, 0);
    rd("R3 epc zeroed", 12'h341);
    // R1 wbEn low and no-op codes
    step("R1 wbEn low", 12'h342, 3'b001, 5'd1, 64'h55, 0, 0, 0, 0);
    step("R1 op 100", 12'h342, 3'b100, 5'd7, 64'h55, 1, 0, 0, 0);
    rd("R1 cause untouched", 12'h342);
    // R2 unmapped address
    step("R2 unmapped write", 12'h7C0, 3'b001, 5'd1, 64'h5, 1, 0, 0, 0);
    rd("R2 unmapped read", 12'h7C0);
    // R4 R5 cycle counter
    rd("R4 cycle a", 12'hB00);
    rd("R4 cycle b", 12'hB00);
    step("R5 cycle write", 12'hB00, 3'b001, 5'd1, 64'd1000, 1, 0, 0, 0);
    rd("R5 cycle loaded", 12'hB00);
    rd("R4 cycle after load", 12'hB00);
    step("R5 cycle set", 12'hB00, 3'b110, 5'd16, 64'd0, 1, 0, 0, 0);
    rd("R5 cycle after set", 12'hB00);
    // R6 R7 trap
    step("R7 enable MIE", 12'h300, 3'b001, 5'd1, 64'h8, 1, 0, 0, 0);
    step("R6 trap", 12'h300, 3'b000, 5'd0, 64'd0, 0, 1, 64'h0000_0000_0000_1234, 0);
    rd("R7 status after trap", 12'h300);
    rd("R6 cause", 12'h342);
    rd("R6 epc", 12'h341);
    // R8 return
    step("R8 mret", 12'h300, 3'b000, 5'd0, 64'd0, 0, 0, 64'd0, 1);
    rd("R8 status after mret", 12'h300);
    // R9 trap with CSR write and trap with mret
    step("R9 trap over write", 12'h342, 3'b001, 5'd1, 64'h77, 1, 1, 64'h2000, 0);
    rd("R9 cause after trap", 12'h342);
    step("R9 trap over mret", 12'h341, 3'b000, 5'd0, 64'd0, 0, 1, 64'h3000, 1);
    rd("R9 epc", 12'h341);
    step("R9 mret over write", 12'h341, 3'b001, 5'd1, 64'h99, 1, 0, 64'd0, 1);
    rd("R9 epc kept", 12'h341);
    step("R8 trap then", 12'h305, 3'b000, 5'd0, 64'd0, 0, 1, 64'h4444, 0);
    step("R8 immediate mret", 12'h305, 3'b000, 5'd0, 64'd0, 0, 0, 64'd0, 1);
    rd("R9 idle", 12'h300);
    #2;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule